// File: doc/BRIEF.md
# Keyed Clock-Manager Register File

This block is the software-facing register file of a clock manager. It decodes single-word reads and writes in an 8 KiB window and keeps the control words for a set of PLLs, their output channels and the downstream clock multiplexers. Every write must carry an 8-bit key in its top byte. A write with the wrong key is thrown away and raises a sticky error flag. A write with the right key is stored with the key byte cleared.

After each accepted write the block sends a one-cycle, one-hot update pulse to the clock element that owns the word. A PLL's control word also governs that PLL's channels, so a write to it pulses every channel of that PLL as well. One word is not stored: the lock-status word, which is formed on each read from the power-down and analog-reset bits of the PLL control words. The PLLs, dividers and multiplexers are not part of this block. They consume the update pulses and the `pll_locked` vector.

Top module: `clkreg_top`

## Requirements
- R1: A write whose bits [31:24] differ from KEY (default 8'h5A) changes no register and raises no update pulse.
- R2: An accepted write stores the data with bits [31:24] cleared, so a read of a stored word always returns 0 in bits [31:24].
- R3: Only accesses with bus_addr[1:0]==0 and bus_be==4'hF are accepted. Any other write is dropped with no pulse. Any other read still answers, with data 0.
- R4: bus_rvalid is high for exactly the one cycle after a read request, and bus_rdata holds the addressed word in that cycle.
- R5: The lock word sits at byte 0x10 (word NUM_PLL). Its bit p is 1 when both bit 0 (power-down) and bit 1 (analog reset) of PLL p's control word are 0. Writes to the lock word have no effect.
- R6: After reset, each PLL control word (byte 4p) reads 0x1. Each channel word (byte 0x18+4c) reads 0x100. Each mux control word reads 0x0 and each mux divisor word reads 0x1000. key_err is 0, the lock word reads 0, and all update pulses are low.
- R7: An accepted write to PLL p's control word raises pll_upd[p]. In the cycle after the write edge it also raises chan_upd for all CH_PER_PLL channels of that PLL (channel c belongs to PLL c/CH_PER_PLL). These pulses last one cycle.
- R8: An accepted write to channel c's word raises chan_upd[c] alone for one cycle.
- R9: Mux m has its control word at byte 0x38+8m and its divisor word 4 bytes higher. An accepted write to either word raises mux_upd[m] alone for one cycle.
- R10: A wrong-key write sets key_err. A read of the status word at byte 0x14 returns key_err in bit 0 and then clears it.
- R11: A word at or beyond byte 4*NUM_REGS (default 0x58) reads 0, and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, one access per cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 13 | Byte address within the window |
| bus_be | input | 4 | Byte enables, all four must be set |
| bus_wdata | input | 32 | Write data with key in bits [31:24] |
| bus_rvalid | output | 1 | Read data valid, one cycle after the request |
| bus_rdata | output | 32 | Read data |
| key_err | output | 1 | Sticky wrong-key flag |
| pll_locked | output | NUM_PLL | Per-PLL lock status |
| pll_upd | output | NUM_PLL | One-hot PLL update pulse |
| chan_upd | output | NUM_PLL*CH_PER_PLL | Channel update pulses |
| mux_upd | output | NUM_MUX | One-hot mux update pulse |

## Verification
The assertions assume that the bus presents at most one access per cycle and that bus_valid is low, or its controls are stable, during reset. The bench drives one access at a time on the falling edge and holds bus_valid high for a single cycle. Wrong keys and partial byte enables are therefore applied as separate transactions, never overlapping with a read of the status word. As a result, setting and clearing key_err never collide.

// File: rtl/clkreg_pkg.sv
package clkreg_pkg;

  typedef enum logic [2:0] {
    K_PLL, K_LOCK, K_ERR, K_CHAN, K_MUX, K_NONE
  } reg_kind_e;

  // Word layout: PLL words, lock word, status word, channels, mux pairs.
  function automatic reg_kind_e kind_of(int idx, int np, int nc, int nm);
    if (idx < np)                   return K_PLL;
    if (idx == np)                  return K_LOCK;
    if (idx == np + 1)              return K_ERR;
    if (idx < np + 2 + nc)          return K_CHAN;
    if (idx < np + 2 + nc + 2 * nm) return K_MUX;
    return K_NONE;
  endfunction

  function automatic logic [31:0] default_of(int idx, int np, int nc, int nm);
    case (kind_of(idx, np, nc, nm))
      K_PLL:   return 32'h0000_0001;
      K_CHAN:  return 32'h0000_0100;
      K_MUX:   return (((idx - (np + 2 + nc)) % 2) == 1) ? 32'h0000_1000 : 32'h0;
      default: return 32'h0;
    endcase
  endfunction

endpackage

// File: rtl/clkreg_front.sv
module clkreg_front
  import clkreg_pkg::*;
#(
  parameter int AW       = 13,
  parameter int NUM_PLL  = 4,
  parameter int NUM_CH   = 8,
  parameter int NUM_MUX  = 4,
  parameter logic [7:0] KEY = 8'h5A,
  localparam int IW      = AW - 2
) (
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [3:0]    bus_be,
  input  logic [31:0]   bus_wdata,
  output logic          acc_ok,
  output logic          key_ok,
  output logic [IW-1:0] widx,
  output reg_kind_e     kind,
  output logic          wr_store,
  output logic          wr_fire,
  output logic          wr_bad_key,
  output logic [31:0]   wval
);
  always_comb begin
    acc_ok     = bus_valid && (bus_addr[1:0] == 2'b00) && (bus_be == 4'hF);
    key_ok     = (bus_wdata[31:24] == KEY);
    widx       = bus_addr[AW-1:2];
    kind       = kind_of(int'(widx), NUM_PLL, NUM_CH, NUM_MUX);
    wr_fire    = acc_ok && bus_write && key_ok;
    wr_store   = wr_fire && (kind == K_PLL || kind == K_CHAN || kind == K_MUX);
    wr_bad_key = acc_ok && bus_write && !key_ok;
    wval       = {8'h00, bus_wdata[23:0]};
  end
endmodule

// File: rtl/clkreg_store.sv
module clkreg_store
  import clkreg_pkg::*;
#(
  parameter int NUM_PLL  = 4,
  parameter int NUM_CH   = 8,
  parameter int NUM_MUX  = 4,
  parameter int IW       = 11,
  localparam int NUM_REGS = NUM_PLL + 2 + NUM_CH + 2 * NUM_MUX
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         we,
  input  logic [IW-1:0]                widx,
  input  logic [31:0]                  wval,
  output logic [NUM_REGS-1:0][31:0]    regs
);
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (rst)
        regs[i] <= default_of(i, NUM_PLL, NUM_CH, NUM_MUX);
      else if (we && int'(widx) == i)
        regs[i] <= wval;
    end
  end
endmodule

// File: rtl/clkreg_lock.sv
module clkreg_lock #(
  parameter int NUM_PLL = 4
) (
  input  logic [NUM_PLL-1:0][1:0] pll_ctl,
  output logic [NUM_PLL-1:0]      locked
);
  // bit 0 = power-down, bit 1 = analog reset
  for (genvar p = 0; p < NUM_PLL; p++) begin : g_lock
    assign locked[p] = ~pll_ctl[p][0] & ~pll_ctl[p][1];
  end
endmodule

// File: rtl/clkreg_strobe.sv
module clkreg_strobe
  import clkreg_pkg::*;
#(
  parameter int NUM_PLL    = 4,
  parameter int CH_PER_PLL = 2,
  parameter int NUM_MUX    = 4,
  parameter int IW         = 11,
  localparam int NUM_CH    = NUM_PLL * CH_PER_PLL,
  localparam int CH_BASE   = NUM_PLL + 2,
  localparam int MUX_BASE  = CH_BASE + NUM_CH
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  reg_kind_e          kind,
  input  logic [IW-1:0]      widx,
  output logic [NUM_PLL-1:0] pll_upd,
  output logic [NUM_CH-1:0]  chan_upd,
  output logic [NUM_MUX-1:0] mux_upd
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pll_upd  <= '0;
      chan_upd <= '0;
      mux_upd  <= '0;
    end else begin
      pll_upd  <= '0;
      chan_upd <= '0;
      mux_upd  <= '0;
      if (fire) begin
        for (int p = 0; p < NUM_PLL; p++)
          if (kind == K_PLL && int'(widx) == p) pll_upd[p] <= 1'b1;
        for (int c = 0; c < NUM_CH; c++) begin
          if (kind == K_PLL && int'(widx) == c / CH_PER_PLL) chan_upd[c] <= 1'b1;
          if (kind == K_CHAN && int'(widx) == CH_BASE + c)    chan_upd[c] <= 1'b1;
        end
        for (int m = 0; m < NUM_MUX; m++)
          if (kind == K_MUX && (int'(widx) - MUX_BASE) / 2 == m) mux_upd[m] <= 1'b1;
      end
    end
  end

  assert_pll_onehot_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(pll_upd));
  assert_mux_onehot_R9: assert property (@(posedge clk) disable iff (rst)
    $countones(mux_upd) <= 1);
  for (genvar p = 0; p < NUM_PLL; p++) begin : g_chk
    assert_pll_pulls_chans_R7: assert property (@(posedge clk) disable iff (rst)
      pll_upd[p] |-> (&chan_upd[p*CH_PER_PLL +: CH_PER_PLL]));
  end
  assert_pulse_one_cycle_R8: assert property (@(posedge clk) disable iff (rst)
    !fire |=> (chan_upd == '0 && mux_upd == '0 && pll_upd == '0));
endmodule

// File: rtl/clkreg_top.sv
module clkreg_top
  import clkreg_pkg::*;
#(
  parameter int WIN_BYTES  = 8192,
  parameter int NUM_PLL    = 4,
  parameter int CH_PER_PLL = 2,
  parameter int NUM_MUX    = 4,
  parameter logic [7:0] KEY = 8'h5A,
  localparam int AW        = $clog2(WIN_BYTES),
  localparam int IW        = AW - 2,
  localparam int NUM_CH    = NUM_PLL * CH_PER_PLL,
  localparam int NUM_REGS  = NUM_PLL + 2 + NUM_CH + 2 * NUM_MUX
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_valid,
  input  logic               bus_write,
  input  logic [AW-1:0]      bus_addr,
  input  logic [3:0]         bus_be,
  input  logic [31:0]        bus_wdata,
  output logic               bus_rvalid,
  output logic [31:0]        bus_rdata,
  output logic               key_err,
  output logic [NUM_PLL-1:0] pll_locked,
  output logic [NUM_PLL-1:0] pll_upd,
  output logic [NUM_CH-1:0]  chan_upd,
  output logic [NUM_MUX-1:0] mux_upd
);
  logic                      acc_ok, key_ok, wr_store, wr_fire, wr_bad_key;
  logic [IW-1:0]             widx;
  reg_kind_e                 kind;
  logic [31:0]               wval;
  logic [NUM_REGS-1:0][31:0] regs;
  logic [NUM_PLL-1:0][1:0]   pll_ctl;
  logic [31:0]               rd_word;

  clkreg_front #(.AW(AW), .NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH),
                 .NUM_MUX(NUM_MUX), .KEY(KEY)) front_i (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .acc_ok(acc_ok), .key_ok(key_ok),
    .widx(widx), .kind(kind), .wr_store(wr_store), .wr_fire(wr_fire),
    .wr_bad_key(wr_bad_key), .wval(wval));

  clkreg_store #(.NUM_PLL(NUM_PLL), .NUM_CH(NUM_CH), .NUM_MUX(NUM_MUX),
                 .IW(IW)) store_i (
    .clk(clk), .rst(rst), .we(wr_store), .widx(widx), .wval(wval), .regs(regs));

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_ctl
    assign pll_ctl[p] = regs[p][1:0];
  end

  clkreg_lock #(.NUM_PLL(NUM_PLL)) lock_i (.pll_ctl(pll_ctl), .locked(pll_locked));

  clkreg_strobe #(.NUM_PLL(NUM_PLL), .CH_PER_PLL(CH_PER_PLL),
                  .NUM_MUX(NUM_MUX), .IW(IW)) strobe_i (
    .clk(clk), .rst(rst), .fire(wr_fire), .kind(kind), .widx(widx),
    .pll_upd(pll_upd), .chan_upd(chan_upd), .mux_upd(mux_upd));

  always_comb begin
    rd_word = '0;
    case (kind)
      K_LOCK:  rd_word = {{(32-NUM_PLL){1'b0}}, pll_locked};
      K_ERR:   rd_word = {31'b0, key_err};
      K_NONE:  rd_word = '0;
      default:
        for (int i = 0; i < NUM_REGS; i++)
          if (int'(widx) == i) rd_word = regs[i];
    endcase
    if (!acc_ok) rd_word = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      key_err    <= 1'b0;
    end else begin
      bus_rvalid <= bus_valid && !bus_write;
      if (bus_valid && !bus_write) bus_rdata <= rd_word;
      if (wr_bad_key)
        key_err <= 1'b1;
      else if (acc_ok && !bus_write && kind == K_ERR)
        key_err <= 1'b0;
    end
  end

  assert_bad_key_no_pulse_R1: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && bus_write && !key_ok) |=> (pll_upd == '0 && chan_upd == '0 && mux_upd == '0));
  assert_bad_key_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && bus_write && !key_ok) |=> key_err);
  assert_read_answers_R4: assert property (@(posedge clk) disable iff (rst)
    (bus_valid && !bus_write) |=> bus_rvalid);
  assert_no_key_readback_R2: assert property (@(posedge clk) disable iff (rst)
    (acc_ok && !bus_write && (kind == K_PLL || kind == K_CHAN || kind == K_MUX))
      |=> (bus_rdata[31:24] == 8'h00));
endmodule

// File: tb/clkreg_top_tb_top.sv
module clkreg_top_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [12:0] bus_addr = '0;
  logic [3:0]  bus_be = 4'hF;
  logic [31:0] bus_wdata = '0;
  logic        bus_rvalid, key_err;
  logic [31:0] bus_rdata;
  logic [3:0]  pll_locked, pll_upd, mux_upd;
  logic [7:0]  chan_upd;
  logic [3:0]  cap_pll, cap_mux;
  logic [7:0]  cap_chan;
  int total = 0, bad = 0, cycles = 0;

  always #2.5 clk = ~clk;

  clkreg_top dut_i (.clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rvalid(bus_rvalid),
    .bus_rdata(bus_rdata), .key_err(key_err), .pll_locked(pll_locked),
    .pll_upd(pll_upd), .chan_upd(chan_upd), .mux_upd(mux_upd));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [12:0] a, logic [31:0] d, logic [3:0] be = 4'hF);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(posedge clk); @(negedge clk);
    cap_pll = pll_upd; cap_chan = chan_upd; cap_mux = mux_upd;
    bus_valid = 0; bus_write = 0; bus_be = 4'hF;
  endtask

  task automatic rd(logic [12:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(posedge clk); @(negedge clk);
    chk("R4 rvalid", {31'b0, bus_rvalid}, 32'h1);
    d = bus_rdata;
    bus_valid = 0;
    @(negedge clk);
    chk("R4 rvalid one cycle", {31'b0, bus_rvalid}, 32'h0);
  endtask

  task automatic chk_pulses(string tag, logic [3:0] p, logic [7:0] c, logic [3:0] m);
    chk({tag, " pll_upd"}, {28'b0, cap_pll}, {28'b0, p});
    chk({tag, " chan_upd"}, {24'b0, cap_chan}, {24'b0, c});
    chk({tag, " mux_upd"}, {28'b0, cap_mux}, {28'b0, m});
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R6 key_err", {31'b0, key_err}, 32'h0);
    chk("R6 pulses", {16'b0, pll_upd, chan_upd, mux_upd}, 32'h0);
    for (int p = 0; p < 4; p++) begin rd(13'(4*p), d); chk("R6 pll word", d, 32'h1); end
    for (int c = 0; c < 8; c++) begin rd(13'(24 + 4*c), d); chk("R6 chan word", d, 32'h100); end
    for (int m = 0; m < 4; m++) begin
      rd(13'(56 + 8*m), d); chk("R6 mux ctl", d, 32'h0);
      rd(13'(60 + 8*m), d); chk("R6 mux div", d, 32'h1000);
    end
    rd(13'h10, d); chk("R6 lock word", d, 32'h0);
  endtask

  task automatic t_bad_key();
    logic [31:0] d;
    wr(13'h0, 32'h1200_0000);
    chk_pulses("R1", 4'h0, 8'h0, 4'h0);
    chk("R10 err set", {31'b0, key_err}, 32'h1);
    rd(13'h0, d); chk("R1 pll0 unchanged", d, 32'h1);
    rd(13'h14, d); chk("R10 status read", d, 32'h1);
    chk("R10 err cleared", {31'b0, key_err}, 32'h0);
    rd(13'h14, d); chk("R10 status after clear", d, 32'h0);
  endtask

  task automatic t_channel();
    logic [31:0] d;
    wr(13'h24, 32'h5A00_0ABC);
    chk_pulses("R8", 4'h0, 8'h08, 4'h0);
    @(negedge clk);
    chk("R8 pulse gone", {16'b0, pll_upd, chan_upd, mux_upd}, 32'h0);
    rd(13'h24, d); chk("R2 key stripped", d, 32'h0000_0ABC);
  endtask

  task automatic t_pll_lock();
    logic [31:0] d;
    wr(13'h4, 32'h5A00_0000);
    chk_pulses("R7", 4'h2, 8'h0C, 4'h0);
    chk("R5 locked port", {28'b0, pll_locked}, 32'h2);
    rd(13'h10, d); chk("R5 lock pll1", d, 32'h2);
    wr(13'h8, 32'h5A00_0002);
    chk_pulses("R7 pll2", 4'h4, 8'h30, 4'h0);
    rd(13'h10, d); chk("R5 anarst blocks lock", d, 32'h2);
    wr(13'h8, 32'h5A00_0000);
    rd(13'h10, d); chk("R5 lock pll1 pll2", d, 32'h6);
    wr(13'h10, 32'h5A00_000F);
    chk_pulses("R5 lock write", 4'h0, 8'h0, 4'h0);
    rd(13'h10, d); chk("R5 lock write ignored", d, 32'h6);
  endtask

  task automatic t_mux();
    logic [31:0] d;
    wr(13'h4C, 32'h5A00_3800);
    chk_pulses("R9 div", 4'h0, 8'h0, 4'h4);
    wr(13'h48, 32'h5A00_0015);
    chk_pulses("R9 ctl", 4'h0, 8'h0, 4'h4);
    wr(13'h38, 32'h5A00_0001);
    chk_pulses("R9 mux0", 4'h0, 8'h0, 4'h1);
    rd(13'h4C, d); chk("R9 div readback", d, 32'h3800);
    rd(13'h48, d); chk("R9 ctl readback", d, 32'h15);
  endtask

  task automatic t_access();
    logic [31:0] d;
    wr(13'h0E, 32'h5A00_0000);
    chk_pulses("R3 misaligned", 4'h0, 8'h0, 4'h0);
    wr(13'h0C, 32'h5A00_0000, 4'h3);
    chk_pulses("R3 partial", 4'h0, 8'h0, 4'h0);
    rd(13'h0C, d); chk("R3 pll3 unchanged", d, 32'h1);
    rd(13'h26, d); chk("R3 misaligned read", d, 32'h0);
    chk("R3 no error flag", {31'b0, key_err}, 32'h0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(13'h100, 32'h5A00_1234);
    chk_pulses("R11", 4'h0, 8'h0, 4'h0);
    rd(13'h100, d); chk("R11 read zero", d, 32'h0);
    rd(13'h58, d); chk("R11 first unmapped", d, 32'h0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_bad_key();
    t_channel();
    t_pll_lock();
    t_mux();
    t_access();
    t_unmapped();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule